// File: doc/BRIEF.md
# Low-Power Mode State Controller

This block tracks the power state of a processor core after it executes a sleep instruction. A one-cycle sleep request moves the core out of the running state into one of three low-power modes. The mode is picked from a single mode bit in each of two standby control register values. Each mode stops a different group of peripheral units. Plain sleep halts only the core and leaves every peripheral running. Deep sleep removes the run enable of the DMA unit. Standby removes the run enables of the timer and the serial port, but only once each unit signals that it is idle.

A pending interrupt or a reset brings the core back to the running state. Every run enable that the left mode cleared comes back in the same cycle. The current state is an output, so the core and the clock logic can use it.

Top module: `lpPowerCtl`

## Requirements
- R1: While reset (rstN low) is asserted, the state output is 0 (running) and the timer, serial and DMA run enables are all 1. This applies at once, including when reset arrives during a low-power mode.
- R2: A sleep request while running, with irqPend low and bit 7 of stbyCtlA set, makes the state read 3 (standby) after the next clock edge. This holds whatever stbyCtlB holds.
- R3: A sleep request while running, with irqPend low and bit 7 of stbyCtlA clear, gives state 2 (deep sleep) if bit 7 of stbyCtlB is set and state 1 (sleep) otherwise. Bits other than bit 7 of either register have no effect.
- R4: Deep sleep clears dmaRunEn at the same edge that the state becomes 2. tmrRunEn and sciRunEn stay 1.
- R5: In standby, tmrRunEn falls at the edge that ends a cycle spent in state 3 with tmrIdle high. sciRunEn does the same with sciIdle. Each enable stays 1 while its idle input is low, and dmaRunEn stays 1.
- R6: Plain sleep (state 1) leaves all three run enables at 1.
- R7: irqPend high in any low-power state returns the state to 0 at the next edge, with all three run enables back at 1 at that same edge.
- R8: A sleep request arriving while the state is not 0 is ignored: the state does not change.
- R9: A sleep request in the same cycle as irqPend high leaves the state at 0 and the enables unchanged.
- R10: A run enable cleared by a low-power mode stays 0 until a wakeup or a reset, even if the unit's idle input later goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sleepReq | input | 1 | One-cycle pulse from the sleep instruction |
| stbyCtlA | input | CTRL_W | First standby control register value; bit MODE_BIT selects standby |
| stbyCtlB | input | CTRL_W | Second standby control register value; bit MODE_BIT selects deep sleep |
| irqPend | input | 1 | An interrupt is pending |
| tmrIdle | input | 1 | The timer unit has finished its current activity |
| sciIdle | input | 1 | The serial port unit has finished its current activity |
| pwrState | output | 2 | 0 running, 1 sleep, 2 deep sleep, 3 standby |
| tmrRunEn | output | 1 | Run enable of the timer unit |
| sciRunEn | output | 1 | Run enable of the serial port unit |
| dmaRunEn | output | 1 | Run enable of the DMA unit |

## Verification
The assertions assume that sleepReq is a one-cycle pulse. They also assume that the control register values do not change in the cycle the request is sampled. The stimulus changes all inputs only just after a rising edge, so every input is stable for a whole cycle. The idle inputs stay low until the bench wants a unit to finish, so the drain in standby can be seen step by step. The mode sweep covers all eight combinations of the two mode bits and the same-cycle interrupt. The other register bits carry changing filler patterns in that sweep.

// File: rtl/lp_pkg.sv
package lp_pkg;

  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_SLEEP = 2'd1,
    PS_DEEP  = 2'd2,
    PS_STBY  = 2'd3
  } lpStateT;

  // strobes from control to the enable datapath
  typedef struct packed {
    logic wake;       // leave any low-power state this edge
    logic enterDeep;  // entering deep sleep this edge
    logic drain;      // standby in force, idle units may be stopped
  } lpStrobeT;

endpackage

// File: rtl/lpModeCtrl.sv
module lpModeCtrl
  import lp_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     sleepReq,
  input  logic     selStby,
  input  logic     selDeep,
  input  logic     irqPend,
  output lpStateT  state,
  output lpStrobeT strobe
);

  lpStateT nextState;
  logic    reqTaken;

  assign reqTaken = (state == PS_RUN) && sleepReq && !irqPend;

  always_comb begin
    nextState = state;
    if (state == PS_RUN) begin
      if (reqTaken) begin
        if (selStby)      nextState = PS_STBY;
        else if (selDeep) nextState = PS_DEEP;
        else              nextState = PS_SLEEP;
      end
    end else if (irqPend) begin
      nextState = PS_RUN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PS_RUN;
    else       state <= nextState;
  end

  always_comb begin
    strobe.wake      = (state != PS_RUN) && irqPend;
    strobe.enterDeep = reqTaken && !selStby && selDeep;
    strobe.drain     = (state == PS_STBY) && !irqPend;
  end

  AST_STBY_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_RUN && sleepReq && !irqPend && selStby) |=> state == PS_STBY); // R2
  AST_DEEP_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_RUN && sleepReq && !irqPend && !selStby && selDeep) |=> state == PS_DEEP); // R3
  AST_WAKE_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (state != PS_RUN && irqPend) |=> state == PS_RUN); // R7
  AST_HOLD_ASLEEP: assert property (@(posedge clk) disable iff (!rstN)
    (state != PS_RUN && !irqPend) |=> $stable(state)); // R8
  AST_IRQ_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_RUN && sleepReq && irqPend) |=> state == PS_RUN); // R9

endmodule

// File: rtl/lpEnableDp.sv
module lpEnableDp
  import lp_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  lpStrobeT strobe,
  input  logic     tmrIdle,
  input  logic     sciIdle,
  output logic     tmrRunEn,
  output logic     sciRunEn,
  output logic     dmaRunEn
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrRunEn <= 1'b1;
      sciRunEn <= 1'b1;
      dmaRunEn <= 1'b1;
    end else if (strobe.wake) begin
      tmrRunEn <= 1'b1;
      sciRunEn <= 1'b1;
      dmaRunEn <= 1'b1;
    end else begin
      if (strobe.enterDeep)          dmaRunEn <= 1'b0;
      if (strobe.drain && tmrIdle)   tmrRunEn <= 1'b0;
      if (strobe.drain && sciIdle)   sciRunEn <= 1'b0;
    end
  end

  AST_WAKE_ALL_ON: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wake |=> (tmrRunEn && sciRunEn && dmaRunEn)); // R7
  AST_DMA_ONLY_DEEP: assert property (@(posedge clk) disable iff (!rstN)
    (dmaRunEn && !strobe.enterDeep) |=> dmaRunEn); // R4
  AST_TMR_BUSY_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (tmrRunEn && !tmrIdle) |=> tmrRunEn); // R5
  AST_TMR_STAYS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!tmrRunEn && !strobe.wake) |=> !tmrRunEn); // R10
  AST_SCI_STAYS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!sciRunEn && !strobe.wake) |=> !sciRunEn); // R10

endmodule

// File: rtl/lpPowerCtl.sv
module lpPowerCtl
  import lp_pkg::*;
#(
  parameter int CTRL_W   = 8,
  parameter int MODE_BIT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sleepReq,
  input  logic [CTRL_W-1:0] stbyCtlA,
  input  logic [CTRL_W-1:0] stbyCtlB,
  input  logic              irqPend,
  input  logic              tmrIdle,
  input  logic              sciIdle,
  output logic [1:0]        pwrState,
  output logic              tmrRunEn,
  output logic              sciRunEn,
  output logic              dmaRunEn
);

  lpStateT  state;
  lpStrobeT strobe;
  logic     unusedCtl;

  assign unusedCtl = ^{stbyCtlA, stbyCtlB};

  lpModeCtrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .sleepReq (sleepReq),
    .selStby  (stbyCtlA[MODE_BIT]),
    .selDeep  (stbyCtlB[MODE_BIT]),
    .irqPend  (irqPend),
    .state    (state),
    .strobe   (strobe)
  );

  lpEnableDp dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .tmrIdle  (tmrIdle),
    .sciIdle  (sciIdle),
    .tmrRunEn (tmrRunEn),
    .sciRunEn (sciRunEn),
    .dmaRunEn (dmaRunEn)
  );

  assign pwrState = state;

  AST_SLEEP_KEEPS_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_SLEEP) |-> (tmrRunEn && sciRunEn && dmaRunEn)); // R6

endmodule

// File: tb/lpPowerCtl_tb_top.sv
module lpPowerCtl_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sleepReq = 1'b0;
  logic [7:0] stbyCtlA = 8'h00;
  logic [7:0] stbyCtlB = 8'h00;
  logic       irqPend = 1'b0;
  logic       tmrIdle = 1'b0;
  logic       sciIdle = 1'b0;
  logic [1:0] pwrState;
  logic       tmrRunEn, sciRunEn, dmaRunEn;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  lpPowerCtl dut_i (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .stbyCtlA(stbyCtlA),
    .stbyCtlB(stbyCtlB), .irqPend(irqPend), .tmrIdle(tmrIdle), .sciIdle(sciIdle),
    .pwrState(pwrState), .tmrRunEn(tmrRunEn), .sciRunEn(sciRunEn), .dmaRunEn(dmaRunEn)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic checkEn(input string req, input int t, input int s, input int d);
    check({req, " tmr"}, int'(tmrRunEn), t);
    check({req, " sci"}, int'(sciRunEn), s);
    check({req, " dma"}, int'(dmaRunEn), d);
  endtask

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #5;
    check("R1 state", int'(pwrState), 0);
    checkEn("R1", 1, 1, 1);
    step(); rstN = 1'b1; step();

    // sweep mode bits, same-cycle irq, filler bits
    for (int m = 0; m < 8; m++) begin
      int a = m & 1;
      int b = (m >> 1) & 1;
      int q = (m >> 2) & 1;
      int expSt = q ? 0 : (a ? 3 : (b ? 2 : 1));
      stbyCtlA = {a[0], 7'(m * 19 + 5)};
      stbyCtlB = {b[0], 7'(~(m * 11))};
      irqPend  = q[0];
      sleepReq = 1'b1;
      step();
      sleepReq = 1'b0; irqPend = 1'b0;
      check("R2 R3 R9 state", int'(pwrState), expSt);
      checkEn("R4 R6 R9", 1, 1, (expSt == 2) ? 0 : 1);
      if (expSt != 0) begin
        stbyCtlA = 8'hFF; stbyCtlB = 8'hFF; sleepReq = 1'b1;
        step();
        sleepReq = 1'b0;
        check("R8 ignored request", int'(pwrState), expSt);
        step();
        check("R8 still asleep", int'(pwrState), expSt);
        irqPend = 1'b1;
        step();
        irqPend = 1'b0;
        check("R7 wake state", int'(pwrState), 0);
        checkEn("R7", 1, 1, 1);
      end
      step();
    end

    // standby drain
    stbyCtlA = 8'h80; stbyCtlB = 8'h80; tmrIdle = 1'b0; sciIdle = 1'b0;
    sleepReq = 1'b1; step(); sleepReq = 1'b0;
    check("R2 standby", int'(pwrState), 3);
    checkEn("R5 entry", 1, 1, 1);
    step(); step();
    checkEn("R5 busy units kept", 1, 1, 1);
    tmrIdle = 1'b1; step();
    checkEn("R5 timer stopped", 0, 1, 1);
    tmrIdle = 1'b0; sciIdle = 1'b1; step();
    checkEn("R10 R5 serial stopped", 0, 0, 1);
    sciIdle = 1'b0; step();
    checkEn("R10 stay off", 0, 0, 1);
    irqPend = 1'b1; step(); irqPend = 1'b0;
    check("R7 wake from standby", int'(pwrState), 0);
    checkEn("R7 restart", 1, 1, 1);
    step();
    checkEn("R7 run steady", 1, 1, 1);

    // reset during deep sleep
    stbyCtlA = 8'h7F; stbyCtlB = 8'h80;
    sleepReq = 1'b1; step(); sleepReq = 1'b0;
    check("R3 deep", int'(pwrState), 2);
    checkEn("R4 deep", 1, 1, 0);
    rstN = 1'b0; #1;
    check("R1 reset in deep", int'(pwrState), 0);
    checkEn("R1 reset in deep", 1, 1, 1);
    step(); rstN = 1'b1; step();
    check("R1 after reset", int'(pwrState), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule